// File: doc/BRIEF.md
# Byte-to-Serial Transmit Serializer

This block turns a byte-wide transmit stream into a single serial bit stream. It runs entirely from a high-rate serial bit clock supplied from outside. It divides that clock by the byte width to produce a parallel-rate clock for upstream logic, and it generates its own load strobe from the same divider. Upstream logic that clocks its byte bus from the divided clock therefore meets the block's capture timing with a large margin.

The datapath has two registers. A holding register captures the byte bus on the rising edge of a separate parallel input clock. In normal use that clock is tied to the divided clock output. A loadable shift register copies the held byte on the load strobe and then shifts one bit per serial clock. The most significant bit goes first. A diagnostic loopback output gives a retimed copy of the serial stream toward a receive path while its enable is high.

Top module: `ser_tx_top`

## Requirements
- R1: The holding register captures the 8-bit `pin` bus on each rising edge of `piclk`.
- R2: `pclk_out` has the serial clock frequency divided by 8. It is low for serial cycles at counts 0 to 3 and high for counts 4 to 7, and count 0 is the first serial cycle after reset is released.
- R3: `ld_strobe` is high for exactly one serial cycle out of every 8, at count 7, which is the last high cycle of `pclk_out`.
- R4: At the serial clock edge that ends a `ld_strobe` cycle, the shift register loads the holding register contents.
- R5: Bits leave on `sdout` most significant bit first. Bit 7 of a byte is driven in the count-0 cycle after its load, and bit 0 in the count-7 cycle.
- R6: A change on `pin` after the capturing `piclk` edge has no effect on the byte sent. The byte sent is the one present at that edge.
- R7: After reset `sdout` stays low until the first load. The first frame after reset is all zeros.
- R8: A synchronous active-high `rst` forces `sdout`, `pclk_out`, `ld_strobe` and `loop_dout` low at the next serial clock edge.
- R9: While `loop_en` is high, `loop_dout` equals `sdout` delayed by one serial cycle.
- R10: While `loop_en` is low, `loop_dout` stays low.
- R11: Bytes presented on successive `pclk_out` periods come out back to back with no gap. A byte driven at a falling edge of `pclk_out` appears on `sdout` during the following `pclk_out` period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| piclk | input | 1 | Parallel input clock for the holding register |
| pin | input | 8 | Parallel transmit byte |
| loop_en | input | 1 | Diagnostic loopback enable |
| pclk_out | output | 1 | Serial clock divided by 8 |
| ld_strobe | output | 1 | One-cycle load strobe, count 7 |
| sdout | output | 1 | Serial data, MSB first |
| loop_dout | output | 1 | Retimed loopback copy of serial data |

## Verification
The bench sends the patterns 0x80 and 0x01 so that a reversed bit order shows up as a swapped byte instead of passing unnoticed. It changes `pin` after the capturing edge; a design that sampled the bus at the load strobe instead of at `piclk` would send the corrupted value. It checks the frame that follows reset, where a missing reset on the shift path or a load placed one phase early would leak ones or stale data. It also asserts reset in the middle of a busy stream, and it compares the loopback output against the serial output one cycle earlier both with the enable on and with it off.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int unsigned SER_BYTE_W = 8;

    typedef struct packed {
        logic pclk;
        logic load;
    } ser_tmg_t;

    function automatic int unsigned ser_cnt_bits(input int unsigned width);
        return (width <= 2) ? 1 : $clog2(width);
    endfunction

endpackage

// File: rtl/ser_timing.sv
module ser_timing
    import ser_pkg::*;
#(
    parameter int unsigned BYTE_W = SER_BYTE_W
) (
    input  logic     clk,
    input  logic     rst,
    output ser_tmg_t tmg
);
    localparam int unsigned CW = ser_cnt_bits(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Divided clock: low for the first half of the count, high for the second.
    assign tmg.pclk = cnt[CW-1];
    // Load strobe on the final count, last high cycle of the divided clock.
    assign tmg.load = (cnt == LAST);
endmodule

// File: rtl/ser_hold.sv
module ser_hold #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] d,
    output logic [BYTE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
    parameter int unsigned BYTE_W    = 8,
    parameter bit          MSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] par,
    output logic              sbit
);
    logic [BYTE_W-1:0] sr;

    generate
        if (MSB_FIRST) begin : g_msb
            always_ff @(posedge clk) begin
                if (rst)
                    sr <= '0;
                else if (load)
                    sr <= par;
                else
                    sr <= {sr[BYTE_W-2:0], 1'b0};
            end
            assign sbit = sr[BYTE_W-1];
        end else begin : g_lsb
            always_ff @(posedge clk) begin
                if (rst)
                    sr <= '0;
                else if (load)
                    sr <= par;
                else
                    sr <= {1'b0, sr[BYTE_W-1:1]};
            end
            assign sbit = sr[0];
        end
    endgenerate
endmodule

// File: rtl/ser_loop.sv
module ser_loop (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic dout
);
    always_ff @(posedge clk) begin
        if (rst)
            dout <= 1'b0;
        else
            dout <= en & din;
    end
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
    import ser_pkg::*;
#(
    parameter int unsigned BYTE_W    = SER_BYTE_W,
    parameter bit          MSB_FIRST = 1'b1
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              piclk,
    input  logic [BYTE_W-1:0] pin,
    input  logic              loop_en,
    output logic              pclk_out,
    output logic              ld_strobe,
    output logic              sdout,
    output logic              loop_dout
);
    ser_tmg_t          tmg;
    logic [BYTE_W-1:0] hold_q;
    logic              lead_bit;

    ser_timing #(.BYTE_W(BYTE_W)) u_tmg (
        .clk (sclk),
        .rst (rst),
        .tmg (tmg)
    );

    ser_hold #(.BYTE_W(BYTE_W)) u_hold (
        .clk (piclk),
        .rst (rst),
        .d   (pin),
        .q   (hold_q)
    );

    ser_shift #(.BYTE_W(BYTE_W), .MSB_FIRST(MSB_FIRST)) u_shift (
        .clk  (sclk),
        .rst  (rst),
        .load (tmg.load),
        .par  (hold_q),
        .sbit (sdout)
    );

    ser_loop u_loop (
        .clk  (sclk),
        .rst  (rst),
        .en   (loop_en),
        .din  (sdout),
        .dout (loop_dout)
    );

    assign pclk_out  = tmg.pclk;
    assign ld_strobe = tmg.load;
    assign lead_bit  = MSB_FIRST ? hold_q[BYTE_W-1] : hold_q[0];
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
    parameter int unsigned BYTE_W = 8
) (
    input logic sclk,
    input logic rst,
    input logic pclk_out,
    input logic ld_strobe,
    input logic sdout,
    input logic loop_en,
    input logic loop_dout,
    input logic lead_bit
);
    localparam int unsigned GW = $clog2(BYTE_W) + 1;

    logic [GW-1:0] gap;
    logic          seen_load;

    always_ff @(posedge sclk) begin
        if (rst) begin
            gap       <= '0;
            seen_load <= 1'b0;
        end else begin
            gap       <= ld_strobe ? '0 : gap + 1'b1;
            seen_load <= seen_load | ld_strobe;
        end
    end

    // R3
    strobe_period_chk: assert property (@(posedge sclk) disable iff (rst)
        ld_strobe |-> (gap == GW'(BYTE_W - 1)));

    // R3
    strobe_in_high_chk: assert property (@(posedge sclk) disable iff (rst)
        ld_strobe |-> pclk_out);

    // R2
    pclk_rise_phase_chk: assert property (@(posedge sclk) disable iff (rst)
        $rose(pclk_out) |-> (gap == GW'(BYTE_W / 2)));

    // R2
    pclk_fall_after_strobe_chk: assert property (@(posedge sclk) disable iff (rst)
        (ld_strobe && !$past(rst)) |=> !pclk_out);

    // R4
    load_first_bit_chk: assert property (@(posedge sclk) disable iff (rst)
        ($past(ld_strobe) && !$past(rst)) |-> (sdout == $past(lead_bit)));

    // R7
    quiet_before_load_chk: assert property (@(posedge sclk) disable iff (rst)
        !seen_load |-> !sdout);

    // R8
    reset_clears_chk: assert property (@(posedge sclk)
        $past(rst) |-> (!sdout && !pclk_out && !ld_strobe && !loop_dout));

    // R9
    loop_follow_chk: assert property (@(posedge sclk) disable iff (rst)
        (!$past(rst) && $past(loop_en)) |-> (loop_dout == $past(sdout)));

    // R10
    loop_off_chk: assert property (@(posedge sclk) disable iff (rst)
        (!$past(rst) && !$past(loop_en)) |-> !loop_dout);
endmodule

bind ser_tx_top ser_tx_chk #(.BYTE_W(BYTE_W)) u_chk (
    .sclk      (sclk),
    .rst       (rst),
    .pclk_out  (pclk_out),
    .ld_strobe (ld_strobe),
    .sdout     (sdout),
    .loop_en   (loop_en),
    .loop_dout (loop_dout),
    .lead_bit  (lead_bit)
);

// File: tb/ser_tx_top_tb.sv
module ser_tx_top_tb;
    localparam int CLK_P = 10;

    logic       sclk = 1'b0;
    logic       rst  = 1'b1;
    logic       piclk;
    logic [7:0] pin  = 8'h00;
    logic       loop_en = 1'b0;
    logic       pclk_out, ld_strobe, sdout, loop_dout;

    int n_chk  = 0;
    int n_fail = 0;

    assign piclk = pclk_out;

    ser_tx_top u_dut (
        .sclk      (sclk),
        .rst       (rst),
        .piclk     (piclk),
        .pin       (pin),
        .loop_en   (loop_en),
        .pclk_out  (pclk_out),
        .ld_strobe (ld_strobe),
        .sdout     (sdout),
        .loop_dout (loop_dout)
    );

    always #(CLK_P/2) sclk = ~sclk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Leaves the bench at the negedge where reset is released (count 0).
    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge sclk);
        rst = 1'b0;
    endtask

    // Streams n bytes from the release of reset and recovers each frame.
    task automatic run_stream(input logic [7:0] data [8], input int n,
                              input bit glitch, input string req);
        logic [7:0] acc = 8'h00;
        logic [7:0] exp;
        int tmg_err = 0;
        do_reset();
        for (int p = 0; p <= n; p++) begin
            for (int m = 0; m < 8; m++) begin
                if (m == 0) pin = (p < n) ? data[p] : 8'h00;
                if (m == 5 && glitch && p < n) pin = ~data[p];
                acc = {acc[6:0], sdout};
                if (pclk_out !== (m >= 4) || ld_strobe !== (m == 7)) tmg_err++;
                @(negedge sclk);
            end
            exp = (p == 0) ? 8'h00 : data[p-1];
            check(acc === exp, (p == 0) ? "R7 first frame" : req, acc, exp);
        end
        // R2 and R3: divided clock and strobe phase per serial cycle
        check(tmg_err == 0, "R2/R3 timing", tmg_err, 0);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        @(negedge sclk);
        @(negedge sclk);
        // R8: outputs at rest while reset is held
        check({sdout, pclk_out, ld_strobe, loop_dout} === 4'b0, "R8 idle", {sdout, pclk_out, ld_strobe, loop_dout}, 0);
    endtask

    task automatic t_fixed_patterns();
        // R1 R4 R11: capture, load and back-to-back frames
        run_stream('{8'hA5, 8'hFF, 8'h00, 8'h3C, 8'hC3, 8'h5A, 8'hFF, 8'h81}, 8, 1'b0, "R11 stream");
    endtask

    task automatic t_bit_order();
        // R5: single-bit bytes expose a reversed bit order
        run_stream('{8'h80, 8'h01, 8'h40, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00}, 4, 1'b0, "R5 order");
    endtask

    task automatic t_random();
        logic [7:0] d [8];
        for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
        run_stream(d, 8, 1'b0, "R1 random");
    endtask

    task automatic t_late_change();
        // R6: pin changed after the capturing edge is ignored
        run_stream('{8'h96, 8'h0F, 8'hE1, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00}, 4, 1'b1, "R6 late change");
    endtask

    task automatic t_loopback(input bit en);
        logic prev = 1'b0;
        int err = 0;
        int ones = 0;
        loop_en = en;
        do_reset();
        for (int c = 0; c < 48; c++) begin
            pin = (c < 24) ? 8'hB6 : 8'hFF;
            if (loop_dout !== (en ? prev : 1'b0)) err++;
            if (sdout === 1'b1) ones++;
            prev = sdout;
            @(negedge sclk);
        end
        check(ones > 0, en ? "R9 stream active" : "R10 stream active", ones, 1);
        if (en) check(err == 0, "R9 loop follows", err, 0);
        else    check(err == 0, "R10 loop quiet", err, 0);
        loop_en = 1'b0;
    endtask

    task automatic t_mid_reset();
        loop_en = 1'b1;
        do_reset();
        pin = 8'hFF;
        repeat (13) @(negedge sclk);
        check(pclk_out === 1'b1 && sdout === 1'b1, "R8 busy before reset", {pclk_out, sdout}, 3);
        rst = 1'b1;
        @(negedge sclk);
        // R8: all outputs low one edge after reset
        check({sdout, pclk_out, ld_strobe, loop_dout} === 4'b0, "R8 mid reset", {sdout, pclk_out, ld_strobe, loop_dout}, 0);
        loop_en = 1'b0;
        do_reset();
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_fixed_patterns();
        t_bit_order();
        t_random();
        t_late_change();
        t_loopback(1'b1);
        t_loopback(1'b0);
        t_mid_reset();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule